// File: doc/BRIEF.md
# Edge-Selectable Sample-Point Tracker

This block recovers a bit sample point from a serial line that is oversampled by a fast sample-clock enable. A phase counter advances once per enable and runs through one bit period. The data bit is captured in the middle of the period. When a transition on the line shows that the counter runs ahead of or behind the real bit boundary, the tracker shortens or lengthens the current bit by one count, so the capture point follows the incoming data.

A two-bit edge selector chooses which transitions may correct the phase: rising only, falling only, both, or none. With none selected, the counter free-runs. A bypass path serves two cases, single-rate clocking and asynchronous framing. In both cases every enable yields a bit directly and the edge selector has no effect. The line passes through a synchronizer before any edge is examined. Line coding and carrier detection are handled elsewhere.

Top module: `dpll_tracker`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `bit_valid` and `bit_data` are 0.
- R2: With no phase correction, `bit_valid` pulses once every 16 sample enables. The pulse comes from the enable at phase count 8. `bit_data` holds the synchronized line level seen at that enable.
- R3: `edge_sel` = 2'b00 lets both rising and falling line transitions correct the phase.
- R4: `edge_sel` = 2'b01 lets only rising (0 to 1) transitions correct the phase. Falling transitions leave the bit length at 16.
- R5: `edge_sel` = 2'b10 lets only falling (1 to 0) transitions correct the phase. Rising transitions leave the bit length at 16.
- R6: `edge_sel` = 2'b11 disables every correction, so every bit lasts 16 enables whatever the line does.
- R7: A correcting transition seen at phase 1 to 7 makes the current bit last 15 enables. One seen at phase 9 to 15 makes it last 17 enables. One seen at phase 0 or 8 leaves it at 16. The correction is applied at the end of the bit, and the last correcting transition in a bit decides it.
- R8: The line passes through two register stages. In bypass, a level driven on `rx_line` before clock edge t appears on `bit_data` after edge t+2 when `samp_en` is held high.
- R9: When `x1_mode` or `async_mode` is 1, `bit_valid` after each clock edge equals `samp_en` at that edge. `bit_data` takes the synchronized line on each enable, and `edge_sel` is ignored.
- R10: `bit_valid` is high for one clock cycle at a time, and only in the cycle after an edge at which `samp_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Oversampling enable, one pulse per sample |
| rx_line | input | 1 | Raw received serial line |
| edge_sel | input | 2 | Correcting-edge select (00 both, 01 rising, 10 falling, 11 none) |
| x1_mode | input | 1 | Single-rate clocking: bypass the tracker |
| async_mode | input | 1 | Asynchronous framing: bypass the tracker |
| bit_valid | output | 1 | One-cycle strobe marking a recovered bit |
| bit_data | output | 1 | Recovered bit value |

## Verification
The assertions check the cycle-by-cycle rules on every cycle:
- the strobe appears only after an enable;
- in tracking mode, a strobe always comes from the centre phase;
- the bypass strobe follows the enable;
- a correcting edge matches the polarity that the selector allows;
- a free-running counter wraps from 15 to 0.

Only the bench scenarios can show the bit lengths of 15, 16 and 17 enables that follow a transition at a chosen phase under each selector value. The same holds for the exact synchronizer delay and the bit values captured while enables, line and modes vary at random.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

    localparam logic [1:0] SEL_BOTH    = 2'b00;
    localparam logic [1:0] SEL_RISING  = 2'b01;
    localparam logic [1:0] SEL_FALLING = 2'b10;
    localparam logic [1:0] SEL_NONE    = 2'b11;

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_comb begin
                chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/dpll_edge_qual.sv
module dpll_edge_qual
    import dpll_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] sel,
    output logic       qual
);

    logic rise;
    logic fall;

    always_comb begin
        rise = cur & ~prev;
        fall = ~cur & prev;
        unique case (sel)
            SEL_BOTH:    qual = rise | fall;
            SEL_RISING:  qual = rise;
            SEL_FALLING: qual = fall;
            default:     qual = 1'b0;
        endcase
    end

endmodule

// File: rtl/dpll_tracker.sv
module dpll_tracker
    import dpll_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       samp_en,
    input  logic       rx_line,
    input  logic [1:0] edge_sel,
    input  logic       x1_mode,
    input  logic       async_mode,
    output logic       bit_valid,
    output logic       bit_data
);

    localparam int            PW     = $clog2(OSR);
    localparam logic [PW-1:0] MID_P  = PW'(OSR / 2);
    localparam logic [PW-1:0] LAST_P = PW'(OSR - 1);
    localparam logic [PW-1:0] ONE_P  = PW'(1);

    typedef struct packed {
        logic [PW-1:0] phase;
        adj_e          adj;
        logic          prev;
        logic          valid;
        logic          bitv;
    } trk_state_t;

    trk_state_t st_d;
    trk_state_t st_q;
    logic       line_s;
    logic       qual;
    logic       bypass;
    adj_e       adj_now;

    dpll_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_line),
        .dout  (line_s)
    );

    dpll_edge_qual u_qual (
        .cur  (line_s),
        .prev (st_q.prev),
        .sel  (edge_sel),
        .qual (qual)
    );

    assign bypass = x1_mode | async_mode;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        adj_now    = st_q.adj;
        if (samp_en) begin
            st_d.prev = line_s;
            if (bypass) begin
                st_d.valid = 1'b1;
                st_d.bitv  = line_s;
                st_d.phase = '0;
                st_d.adj   = ADJ_NONE;
            end else begin
                if (qual) begin
                    if (st_q.phase != '0 && st_q.phase < MID_P) begin
                        adj_now = ADJ_SHORT;
                    end else if (st_q.phase > MID_P) begin
                        adj_now = ADJ_LONG;
                    end else begin
                        adj_now = ADJ_NONE;
                    end
                end
                if (st_q.phase == MID_P) begin
                    st_d.valid = 1'b1;
                    st_d.bitv  = line_s;
                end
                if (st_q.phase == LAST_P) begin
                    unique case (adj_now)
                        ADJ_SHORT: st_d.phase = ONE_P;
                        ADJ_LONG:  st_d.phase = LAST_P;
                        default:   st_d.phase = '0;
                    endcase
                    st_d.adj = ADJ_NONE;
                end else begin
                    st_d.phase = st_q.phase + ONE_P;
                    st_d.adj   = adj_now;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: '0, adj: ADJ_NONE, prev: 1'b0, valid: 1'b0, bitv: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_valid = st_q.valid;
    assign bit_data  = st_q.bitv;

    // R10: a strobe only follows an enable
    a_r10_strobe_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(samp_en));

    // R2: in tracking mode a strobe comes from the centre phase
    a_r2_centre_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !$past(bypass)) |-> ($past(st_q.phase) == MID_P));

    // R9: bypass strobe mirrors the enable
    a_r9_bypass_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && bypass) |=> bit_valid);

    // R6: with corrections off the counter wraps plainly
    a_r6_free_run_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && !bypass && edge_sel == SEL_NONE && st_q.phase == LAST_P
         && st_q.adj == ADJ_NONE) |=> (st_q.phase == '0));

    // R4: rising-only selection never qualifies a falling edge
    a_r4_rising_only: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && edge_sel == SEL_RISING) |-> line_s);

    // R5: falling-only selection never qualifies a rising edge
    a_r5_falling_only: assert property (@(posedge clk) disable iff (!rst_n)
        (qual && edge_sel == SEL_FALLING) |-> !line_s);

endmodule

// File: tb/dpll_tracker_test.sv
module dpll_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_en = 1'b0;
    logic       rx_line = 1'b0;
    logic [1:0] edge_sel = 2'b11;
    logic       x1_mode = 1'b0;
    logic       async_mode = 1'b0;
    logic       bit_valid;
    logic       bit_data;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // reference model state
    logic       m_s1, m_s2, m_prev, m_valid, m_bit;
    int         m_phase;
    int         m_adj; // 0 none, 1 short, 2 long

    dpll_tracker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .rx_line    (rx_line),
        .edge_sel   (edge_sel),
        .x1_mode    (x1_mode),
        .async_mode (async_mode),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc++;

    function automatic bit allowed(input logic [1:0] sel, input logic cur, input logic prv);
        if (cur == prv) return 1'b0;
        case (sel)
            2'b00:   return 1'b1;
            2'b01:   return cur;
            2'b10:   return !cur;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_valid = 0; m_bit = 0;
            m_phase = 0; m_adj = 0;
        end else begin
            logic line;
            int   a;
            line    = m_s2;
            m_valid = 0;
            if (samp_en) begin
                if (x1_mode || async_mode) begin
                    m_valid = 1; m_bit = line; m_phase = 0; m_adj = 0;
                end else begin
                    a = m_adj;
                    if (allowed(edge_sel, line, m_prev))
                        a = (m_phase >= 1 && m_phase <= 7) ? 1 : (m_phase >= 9) ? 2 : 0;
                    if (m_phase == 8) begin m_valid = 1; m_bit = line; end
                    if (m_phase == 15) begin
                        m_phase = (a == 1) ? 1 : (a == 2) ? 15 : 0;
                        m_adj = 0;
                    end else begin
                        m_phase++; m_adj = a;
                    end
                end
                m_prev = line;
            end
            m_s2 = m_s1;
            m_s1 = rx_line;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_valid(output int t);
        int n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!bit_valid && n < 100);
        t = cyc;
    endtask

    // drive a transition to lvl seen by the tracker at phase p, return length of affected bit
    task automatic edge_gap(input logic [1:0] sel, input logic lvl, input int p, output int gap);
        int k, t1, t2, j;
        edge_sel = sel;
        rx_line  = !lvl;
        repeat (3) wait_valid(k);
        wait_valid(k);
        j = (p >= 8) ? p - 8 : p + 8;
        repeat (j - 3) @(posedge clk);
        #1 rx_line = lvl;
        wait_valid(t1);
        if (p >= 8) begin
            gap = t1 - k;
        end else begin
            wait_valid(t2);
            gap = t2 - t1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int g, t0, t1;
        void'($urandom(32'd1234));

        // R1: reset state
        #(CLK_PERIOD * 3 + 2);
        check(bit_valid == 0, "R1 valid in reset", bit_valid, 0);
        check(bit_data == 0, "R1 data in reset", bit_data, 0);
        @(negedge clk) rst_n = 1'b1;
        samp_en = 1'b1;
        @(posedge clk); #1;
        check(bit_valid == 0, "R1 valid after release", bit_valid, 0);

        // R2: free running period and captured level
        edge_sel = 2'b11;
        rx_line  = 1'b1;
        wait_valid(t0);
        wait_valid(t0);
        wait_valid(t1);
        check(t1 - t0 == 16, "R2 period", t1 - t0, 16);
        check(bit_data == 1, "R2 captured bit", bit_data, 1);
        // R10: strobe lasts one cycle
        @(posedge clk); #1;
        check(bit_valid == 0, "R10 single-cycle strobe", bit_valid, 0);

        // R3 / R7: both edges
        edge_gap(2'b00, 1'b1, 4, g);  check(g == 15, "R3 R7 early rising", g, 15);
        check(bit_data == 1, "R2 bit after edge", bit_data, 1);
        edge_gap(2'b00, 1'b0, 12, g); check(g == 17, "R3 R7 late falling", g, 17);
        edge_gap(2'b00, 1'b1, 0, g);  check(g == 16, "R7 phase zero edge", g, 16);
        // R4: rising only
        edge_gap(2'b01, 1'b1, 12, g); check(g == 17, "R4 rising corrects", g, 17);
        edge_gap(2'b01, 1'b0, 12, g); check(g == 16, "R4 falling ignored", g, 16);
        // R5: falling only
        edge_gap(2'b10, 1'b0, 4, g);  check(g == 15, "R5 falling corrects", g, 15);
        edge_gap(2'b10, 1'b1, 4, g);  check(g == 16, "R5 rising ignored", g, 16);
        // R6: none
        edge_gap(2'b11, 1'b1, 12, g); check(g == 16, "R6 late ignored", g, 16);
        edge_gap(2'b11, 1'b0, 4, g);  check(g == 16, "R6 early ignored", g, 16);

        // R8: synchronizer depth in bypass
        x1_mode = 1'b1;
        rx_line = 1'b0;
        repeat (4) @(posedge clk);
        #1 rx_line = 1'b1;            // sampled at edge t
        @(posedge clk); #1;           // after t
        @(posedge clk); #1;           // after t+1
        check(bit_data == 0, "R8 not yet through", bit_data, 0);
        @(posedge clk); #1;           // after t+2
        check(bit_data == 1, "R8 arrives after two stages", bit_data, 1);

        // R9: random bypass and tracking against model
        for (int i = 0; i < 6000; i++) begin
            if (i % 250 == 0) begin
                edge_sel   = 2'($urandom_range(0, 3));
                x1_mode    = ($urandom_range(0, 3) == 0);
                async_mode = ($urandom_range(0, 3) == 0);
            end
            samp_en = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 9) == 0) rx_line = ~rx_line;
            @(posedge clk); #1;
            begin
                string tag;
                if (x1_mode || async_mode) tag = "R9 bypass";
                else case (edge_sel)
                    2'b00: tag = "R3 random";
                    2'b01: tag = "R4 random";
                    2'b10: tag = "R5 random";
                    default: tag = "R6 random";
                endcase
                check(bit_valid == m_valid, {tag, " strobe"}, bit_valid, m_valid);
                if (m_valid) check(bit_data == m_bit, {tag, " data"}, bit_data, m_bit);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule